// File: doc/BRIEF.md
# Multilevel Reverse-Mapping Sequence Generator

This block turns one half-period of an ordinary two-level space-vector switching pattern into per-phase level indices for an inverter with `LEVELS` output levels. The caller supplies the centre of the small hexagon that holds the reference tip, the sector of the reference once it has been shifted into the innermost hexagon, and three dwell counts. The block walks the two-level vectors of that sector and adds the centre to each vector, one phase at a time. No table of multilevel vectors is stored, only the six two-level sector patterns.

One carrier period is symmetric. The first half runs from the all-low vector through the two active vectors to the all-high vector. The second half plays the same steps back in reverse order. Each step holds its level indices on the outputs for its dwell count in clock cycles. A new set of inputs is taken through a valid/ready handshake, and only at a period boundary. When a sum would pass the top level, that phase is clamped and an error flag is set and held.

Top module: `mlv_seq_gen`

## Requirements
- R1: During and after reset the three level outputs are 0, `in_ready` is 1 and `clip_err` is 0.
- R2: Each phase output equals that phase's centre level plus that phase's bit of the current two-level vector. Bit 2 of a vector belongs to phase a, bit 1 to phase b and bit 0 to phase c.
- R3: The first half-period visits 000, V1, V2, 111, where (V1, V2) depends on the sector. Sector 1 gives (100, 110), sector 2 gives (010, 110), sector 3 gives (010, 011), sector 4 gives (001, 011), sector 5 gives (001, 101) and sector 6 gives (100, 101). Sector codes 0 and 7 act as sector 1.
- R4: One period has eight steps: 000, V1, V2, 111, 111, V2, V1, 000. The second half is the first half reversed.
- R5: Each 000 step lasts floor(Tz/2) cycles and each 111 step lasts Tz − floor(Tz/2) cycles. Each V1 step lasts T1 cycles and each V2 step lasts T2 cycles. A step whose count works out to 0 lasts one cycle.
- R6: Within a period, the outputs of two consecutive cycles differ in at most one phase.
- R7: `in_ready` is 1 while idle and in the final cycle of a period, and 0 at all other times. An accepted set of inputs starts step 0 in the next cycle. Inputs offered while `in_ready` is 0 have no effect on the running period.
- R8: Once a period ends and no new inputs arrive, the outputs hold the centre vector (the final 000 step) unchanged.
- R9: A phase sum above `LEVELS`−1 is driven as `LEVELS`−1, and the cycle after it is driven `clip_err` becomes 1. `clip_err` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | New centre, sector and dwell set offered |
| in_ready | output | 1 | Block takes the offered set at this edge |
| ctr_a | input | LW | Centre level index, phase a |
| ctr_b | input | LW | Centre level index, phase b |
| ctr_c | input | LW | Centre level index, phase c |
| sector | input | 3 | Sector 1..6 of the mapped reference |
| t_zero | input | DW | Zero-vector dwell for one half-period |
| t_one | input | DW | Dwell of the first active vector |
| t_two | input | DW | Dwell of the second active vector |
| lvl_a | output | LW | Level index driven on phase a |
| lvl_b | output | LW | Level index driven on phase b |
| lvl_c | output | LW | Level index driven on phase c |
| clip_err | output | 1 | Sticky flag: a phase sum was clamped |

## Verification
The end of one period and the start of the next can fall in the same cycle. The bench holds `in_valid` high with a second input set all through a running period. It expects `in_ready` to be high in exactly the last cycle, and the new step 0 to appear on the very next cycle with no idle gap. A clamp can also arrive on a step boundary. The bench uses a centre at the top level in one phase, then checks the clamped levels for every cycle and checks that the flag stays set through a later clean period.

// File: rtl/mlv_pkg.sv
// Package: shared types and the two-level sector patterns.
// Assumes the phase order a,b,c maps to vector bits 2,1,0.
package mlv_pkg;

    typedef enum logic [1:0] {DS_ZLO, DS_T1, DS_T2, DS_ZHI} dsel_e;

    // Returns {V1, V2}: the two active vectors of a sector, in visiting order.
    function automatic logic [5:0] sector_pair(input logic [2:0] sec);
        logic [5:0] pr;
        case (sec)
            3'd2:    pr = {3'b010, 3'b110};
            3'd3:    pr = {3'b010, 3'b011};
            3'd4:    pr = {3'b001, 3'b011};
            3'd5:    pr = {3'b001, 3'b101};
            3'd6:    pr = {3'b100, 3'b101};
            default: pr = {3'b100, 3'b110};
        endcase
        return pr;
    endfunction

endpackage

// File: rtl/mlv_step_rom.sv
// Step decoder: for a sector and a step 0..7, gives the two-level vector
// and which dwell count applies. Steps 4..7 mirror steps 3..0.
module mlv_step_rom
    import mlv_pkg::*;
(
    input  logic [2:0] sector,
    input  logic [2:0] step,
    output logic [2:0] vec,
    output dsel_e      dsel
);

    logic [5:0] pair;
    assign pair = sector_pair(sector);

    // Purpose: pick the vector and its dwell class from the mirrored step.
    always_comb begin
        case (step)
            3'd1, 3'd6: begin vec = pair[5:3]; dsel = DS_T1;  end
            3'd2, 3'd5: begin vec = pair[2:0]; dsel = DS_T2;  end
            3'd3, 3'd4: begin vec = 3'b111;    dsel = DS_ZHI; end
            default:    begin vec = 3'b000;    dsel = DS_ZLO; end
        endcase
    end

endmodule

// File: rtl/mlv_dwell_timer.sv
// Dwell timer: counts each step for its dwell (minimum one cycle) and
// moves through steps 0..7. It assumes `dur` is valid for the current step.
module mlv_dwell_timer #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] dur,
    output logic          busy,
    output logic [2:0]    step,
    output logic          step_end,
    output logic          period_end
);

    logic [DW-1:0] cnt;
    logic [DW-1:0] dur_eff;

    // Purpose: a zero dwell still occupies one cycle.
    always_comb dur_eff = (dur == '0) ? DW'(1) : dur;

    assign step_end   = busy && (cnt == dur_eff - DW'(1));
    assign period_end = step_end && (step == 3'd7);

    // Purpose: advance cycle count and step index, and end the period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            step <= 3'd7;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            step <= 3'd0;
            cnt  <= '0;
        end else if (busy) begin
            if (step_end) begin
                cnt <= '0;
                if (step == 3'd7) busy <= 1'b0;
                else              step <= step + 3'd1;
            end else begin
                cnt <= cnt + DW'(1);
            end
        end
    end

    // R5: a step is held until its dwell has run out.
    assert_dwell_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !step_end && !start) |=> $stable(step));

    // R4: a period always begins at step 0.
    assert_start_step0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && step == 3'd0));

endmodule

// File: rtl/mlv_level_adder.sv
// Level adder: per phase adds the centre level and the two-level bit,
// clamping at MAXL. Assumes vector bit 2 is phase a (index 2).
module mlv_level_adder #(
    parameter int LW   = 3,
    parameter int MAXL = 4
) (
    input  logic [2:0][LW-1:0] ctr,
    input  logic [2:0]         bits,
    output logic [2:0][LW-1:0] lvl,
    output logic [2:0]         clip
);

    localparam logic [LW:0] TOP = (LW+1)'(MAXL);

    for (genvar p = 0; p < 3; p++) begin : g_phase
        logic [LW:0] sum;
        // Purpose: wide sum of centre and offset bit for one phase.
        always_comb sum = {1'b0, ctr[p]} + {{LW{1'b0}}, bits[p]};
        assign clip[p] = (sum > TOP);
        assign lvl[p]  = clip[p] ? TOP[LW-1:0] : sum[LW-1:0];
    end

endmodule

// File: rtl/mlv_seq_gen.sv
// Top: registers one centre/sector/dwell set per period and drives phase
// level indices through an 8-step symmetric two-level pattern shifted by
// the centre. Assumes LEVELS >= 2; level outputs follow step registers.
module mlv_seq_gen
    import mlv_pkg::*;
#(
    parameter int LEVELS = 5,
    parameter int DW     = 16,
    localparam int LW    = (LEVELS > 2) ? $clog2(LEVELS) : 1,
    localparam int MAXL  = LEVELS - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [LW-1:0] ctr_a,
    input  logic [LW-1:0] ctr_b,
    input  logic [LW-1:0] ctr_c,
    input  logic [2:0]    sector,
    input  logic [DW-1:0] t_zero,
    input  logic [DW-1:0] t_one,
    input  logic [DW-1:0] t_two,
    output logic [LW-1:0] lvl_a,
    output logic [LW-1:0] lvl_b,
    output logic [LW-1:0] lvl_c,
    output logic          clip_err
);

    logic [2:0][LW-1:0] ctr_q;
    logic [2:0]         sec_q;
    logic [DW-1:0]      tz_q, t1_q, t2_q;
    logic [DW-1:0]      z_lo, z_hi, dur;
    logic               busy, step_end, period_end, start;
    logic [2:0]         step, vec, clip;
    dsel_e              dsel;
    logic [2:0][LW-1:0] lvl;

    assign in_ready = !busy || period_end;
    assign start    = in_valid && in_ready;

    // Purpose: capture the input set when a period is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctr_q <= '0;
            sec_q <= 3'd1;
            tz_q  <= '0;
            t1_q  <= '0;
            t2_q  <= '0;
        end else if (start) begin
            ctr_q <= {ctr_a, ctr_b, ctr_c};
            sec_q <= sector;
            tz_q  <= t_zero;
            t1_q  <= t_one;
            t2_q  <= t_two;
        end
    end

    // Purpose: split the zero dwell between the low and high zero vectors.
    always_comb begin
        z_lo = tz_q >> 1;
        z_hi = tz_q - z_lo;
    end

    // Purpose: choose the dwell of the current step.
    always_comb begin
        case (dsel)
            DS_T1:   dur = t1_q;
            DS_T2:   dur = t2_q;
            DS_ZHI:  dur = z_hi;
            default: dur = z_lo;
        endcase
    end

    mlv_step_rom u_rom (
        .sector (sec_q),
        .step   (step),
        .vec    (vec),
        .dsel   (dsel)
    );

    mlv_dwell_timer #(.DW(DW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .dur        (dur),
        .busy       (busy),
        .step       (step),
        .step_end   (step_end),
        .period_end (period_end)
    );

    mlv_level_adder #(.LW(LW), .MAXL(MAXL)) u_add (
        .ctr  (ctr_q),
        .bits (vec),
        .lvl  (lvl),
        .clip (clip)
    );

    assign lvl_a = lvl[2];
    assign lvl_b = lvl[1];
    assign lvl_c = lvl[0];

    // Purpose: sticky flag for any clamped phase during a period.
    always_ff @(posedge clk) begin
        if (!rst_n)              clip_err <= 1'b0;
        else if (busy && |clip)  clip_err <= 1'b1;
    end

    // R7: the block is always ready while idle.
    assert_ready_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> in_ready);

    // R6: consecutive cycles of one period change at most one phase.
    assert_one_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start) |=> ($countones({lvl_a != $past(lvl_a),
                                          lvl_b != $past(lvl_b),
                                          lvl_c != $past(lvl_c)}) <= 1));

    // R9: no phase output exceeds the top level.
    assert_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_a <= LW'(MAXL)) && (lvl_b <= LW'(MAXL)) && (lvl_c <= LW'(MAXL)));

    // R9: the error flag never clears outside reset.
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clip_err |=> clip_err);

    // R8: idle outputs hold still until a new period is accepted.
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(lvl_a) && $stable(lvl_b) && $stable(lvl_c)));

endmodule

// File: tb/tb_mlv_seq_gen.sv
// Directed bench: each task drives one scenario and checks every cycle.
module tb_mlv_seq_gen;

    localparam int LEVELS = 5;
    localparam int DW     = 16;
    localparam int LW     = 3;
    localparam int TOP    = LEVELS - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [LW-1:0] ctr_a = '0, ctr_b = '0, ctr_c = '0;
    logic [2:0]    sector = 3'd1;
    logic [DW-1:0] t_zero = '0, t_one = '0, t_two = '0;
    logic [LW-1:0] lvl_a, lvl_b, lvl_c;
    logic          clip_err;

    int checks = 0;
    int errors = 0;
    bit exp_err = 1'b0;

    always #4 clk = ~clk;

    mlv_seq_gen #(.LEVELS(LEVELS), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .ctr_a(ctr_a), .ctr_b(ctr_b), .ctr_c(ctr_c), .sector(sector),
        .t_zero(t_zero), .t_one(t_one), .t_two(t_two),
        .lvl_a(lvl_a), .lvl_b(lvl_b), .lvl_c(lvl_c), .clip_err(clip_err)
    );

    function automatic int out3();
        return int'(lvl_a) * 100 + int'(lvl_b) * 10 + int'(lvl_c);
    endfunction

    function automatic int clampl(input int v);
        return (v > TOP) ? TOP : v;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Offer an input set at a falling edge; leave valid high after the accept edge.
    task automatic offer(input int ca, cb, cc, sec, tz, t1, t2);
        @(negedge clk);
        ctr_a = LW'(ca); ctr_b = LW'(cb); ctr_c = LW'(cc);
        sector = 3'(sec);
        t_zero = DW'(tz); t_one = DW'(t1); t_two = DW'(t2);
        in_valid = 1'b1;
        @(posedge clk);
    endtask

    task automatic drop_valid();
        #1 in_valid = 1'b0;
    endtask

    // Expected period per R2..R5, R7 and R9, checked on every cycle.
    task automatic expect_period(input int ca, cb, cc, sec, tz, t1, t2, input string tag);
        int v1, v2, zlo, zhi;
        case (sec)
            2: begin v1 = 3'b010; v2 = 3'b110; end
            3: begin v1 = 3'b010; v2 = 3'b011; end
            4: begin v1 = 3'b001; v2 = 3'b011; end
            5: begin v1 = 3'b001; v2 = 3'b101; end
            6: begin v1 = 3'b100; v2 = 3'b101; end
            default: begin v1 = 3'b100; v2 = 3'b110; end
        endcase
        zlo = tz / 2;
        zhi = tz - zlo;
        for (int s = 0; s < 8; s++) begin
            int vec, dur, ea, eb, ec;
            case (s)
                1, 6: begin vec = v1; dur = t1; end
                2, 5: begin vec = v2; dur = t2; end
                3, 4: begin vec = 7;  dur = zhi; end
                default: begin vec = 0; dur = zlo; end
            endcase
            if (dur < 1) dur = 1;
            ea = ca + ((vec >> 2) & 1);
            eb = cb + ((vec >> 1) & 1);
            ec = cc + (vec & 1);
            if (ea > TOP || eb > TOP || ec > TOP) exp_err = 1'b1;
            for (int k = 0; k < dur; k++) begin
                int e;
                @(negedge clk);
                e = clampl(ea) * 100 + clampl(eb) * 10 + clampl(ec);
                chk(out3() == e, {"R2/R3/R4/R5 levels ", tag}, out3(), e);
                chk(in_ready == (s == 7 && k == dur - 1), {"R7 ready ", tag},
                    int'(in_ready), int'(s == 7 && k == dur - 1));
            end
        end
    endtask

    // R8 / R9: idle hold of the clamped centre and the error flag.
    task automatic expect_idle(input int ca, cb, cc, input string tag);
        int e;
        e = clampl(ca) * 100 + clampl(cb) * 10 + clampl(cc);
        repeat (3) begin
            @(negedge clk);
            chk(out3() == e, {"R8 idle hold ", tag}, out3(), e);
            chk(in_ready == 1'b1, {"R7 idle ready ", tag}, int'(in_ready), 1);
            chk(clip_err == exp_err, {"R9 flag ", tag}, int'(clip_err), int'(exp_err));
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out3() == 0, "R1 reset levels", out3(), 0);
        chk(in_ready == 1'b1, "R1 reset ready", int'(in_ready), 1);
        chk(clip_err == 1'b0, "R1 reset flag", int'(clip_err), 0);
        rst_n = 1'b1;
        exp_err = 1'b0;
    endtask

    task automatic t_single(input int ca, cb, cc, sec, esec, tz, t1, t2, input string tag);
        offer(ca, cb, cc, sec, tz, t1, t2);
        drop_valid();
        expect_period(ca, cb, cc, esec, tz, t1, t2, tag);
        expect_idle(ca, cb, cc, tag);
    endtask

    // R7: next set held during a period is taken only in its last cycle.
    task automatic t_back_to_back();
        offer(1, 2, 1, 3, 4, 2, 3);
        #1;
        ctr_a = LW'(2); ctr_b = LW'(0); ctr_c = LW'(3); sector = 3'd6;
        t_zero = DW'(2); t_one = DW'(1); t_two = DW'(2);
        expect_period(1, 2, 1, 3, 4, 2, 3, "b2b first");
        @(posedge clk);
        drop_valid();
        expect_period(2, 0, 3, 6, 2, 1, 2, "b2b second");
        expect_idle(2, 0, 3, "b2b");
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_single(3, 1, 0, 2, 2, 4, 3, 2, "R2 centre 310 sector 2");
        t_single(3, 0, 3, 5, 5, 6, 2, 1, "R3 centre 303 sector 5");
        for (int s = 1; s <= 6; s++)
            t_single(1, 1, 1, s, s, 2, 1, 2, "R3 R6 sector sweep");
        t_single(2, 2, 2, 0, 1, 3, 2, 2, "R3 sector 0 as 1");
        t_single(2, 2, 2, 7, 1, 2, 1, 1, "R3 sector 7 as 1");
        t_single(0, 1, 2, 4, 4, 1, 0, 3, "R5 zero dwells");
        t_single(0, 0, 0, 1, 1, 0, 0, 0, "R5 all zero");
        t_back_to_back();
        t_single(4, 3, 0, 1, 1, 2, 2, 2, "R9 clamp phase a");
        t_single(1, 1, 1, 2, 2, 2, 1, 1, "R9 flag stays set");
        t_reset();
        t_single(4, 4, 4, 5, 5, 2, 1, 1, "R9 clamp two phases");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule